// File: doc/BRIEF.md
# Capture Compare PWM Timer

A general-purpose up-counting timer configured over a simple single-cycle register bus. The counter advances on every functional clock or on a prescaled tick, reloads from a load register on overflow or on software request, and compares itself against a match register. A synchronized external input can latch the running count on a chosen edge, and an output pin produces pulses or a toggling waveform from overflow and compare events.

Three event sources (compare match, overflow, capture) set sticky status bits. Software clears them by writing ones. A single interrupt line is the OR of the status bits that are also enabled. Stopping a running timer also acknowledges a pending overflow, so a restart does not raise a stale interrupt.

Writes take effect on the clock edge where `bus_sel` and `bus_wr` are both high. Reads are combinational from `bus_addr`.

Top module: `cc_pwm_timer`

## Requirements
- R1: Registers sit at byte offsets control 0x00, counter 0x04, load 0x08, trigger 0x0C, match 0x10, capture 0x14, status 0x18 and enable 0x1C. The trigger offset reads zero. After reset every register reads zero, `pwm_out` is 0, `pwm_oe` is 1 and `irq` is 0.
- R2: While control bit 0 (run) is set and the prescaler is off, the counter increases by one on every clock. While run is clear, the counter holds its value.
- R3: A bus write to the counter replaces its value on that edge, whether the timer is running or not. It takes priority over a tick on the same edge, and that tick raises no event.
- R4: A tick that finds the counter at all ones sets status bit 1 (overflow). If control bit 1 (reload) is set, the counter takes the load value. Otherwise the counter becomes zero and run clears.
- R5: When control bit 5 is set, ticks occur once every 2^(P+1) clocks, where P is control bits 4:2. The prescale phase restarts whenever run or bit 5 is clear.
- R6: A write of any value to the trigger offset makes the next tick copy the load value into the counter. That tick raises no overflow.
- R7: When control bit 6 is set, a tick that moves the counter onto the match value sets status bit 0.
- R8: The capture input passes through two synchronizing flops. Control bits 9:8 choose the edge: 00 none, 01 rising, 10 falling, 11 both. On a selected edge, the capture register takes the counter value and status bit 2 is set.
- R9: With control bit 13 set, only every second selected edge captures. The edge phase resets while bit 13 is clear.
- R10: Control bits 11:10 select what drives the output: 0 none, 1 overflow, 2 overflow or match, 3 none. Bit 12 selects toggle (1) or pulse (0). A pulse drives the inverse of bit 7 for one clock. While run is clear, the output rests at the level in bit 7.
- R11: Writing ones to the status register clears those bits, but a new event on the same edge wins. `irq` is high exactly when some status bit and the matching enable bit are both set.
- R12: A control write that clears run while the timer is running also clears the overflow status bit.
- R13: `pwm_oe` is the inverse of control bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| cap_in | input | 1 | Asynchronous capture input |
| pwm_out | output | 1 | Pulse or toggle waveform |
| pwm_oe | output | 1 | Output pin drive enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench compares against a behavioural model on every clock and also makes fixed-value checks.

Counting is tried in free-running mode, at two prescaler divisions and across overflow with and without reload. These cases separate the tick rate from the reload path and from the one-shot stop.

Compare is tried in toggle mode and in pulse mode with a high idle level. These runs show whether the output policy reacts to match events or to overflow events only.

Capture is tried with rising, falling and both-edge selects and with the every-second-edge mode. Absolute counter checks after a trigger write and after a counter write taken mid-run pin down the reload and write priorities cycle by cycle.

// File: rtl/cct_pkg.sv
package cct_pkg;
   localparam int unsigned ADDR_W = 8;
   localparam int unsigned PRE_W  = 3;
   localparam int unsigned IRQ_N  = 3;

   localparam logic [ADDR_W-1:0] A_CTRL  = 8'h00;
   localparam logic [ADDR_W-1:0] A_CNT   = 8'h04;
   localparam logic [ADDR_W-1:0] A_LOAD  = 8'h08;
   localparam logic [ADDR_W-1:0] A_TRIG  = 8'h0C;
   localparam logic [ADDR_W-1:0] A_MATCH = 8'h10;
   localparam logic [ADDR_W-1:0] A_CAPT  = 8'h14;
   localparam logic [ADDR_W-1:0] A_STAT  = 8'h18;
   localparam logic [ADDR_W-1:0] A_IEN   = 8'h1C;

   localparam int unsigned IRQ_MATCH = 0;
   localparam int unsigned IRQ_OVF   = 1;
   localparam int unsigned IRQ_CAP   = 2;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   typedef enum logic [1:0] {
      WAVE_OFF   = 2'd0,
      WAVE_OVF   = 2'd1,
      WAVE_OVFMT = 2'd2,
      WAVE_RSVD  = 2'd3
   } wave_pol_e;

   typedef struct packed {
      logic             out_dis;
      logic             cap_second;
      logic             toggle;
      wave_pol_e        wave_pol;
      edge_sel_e        edge_sel;
      logic             idle_hi;
      logic             cmp_en;
      logic             pre_en;
      logic [PRE_W-1:0] pre_val;
      logic             reload;
      logic             run;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
   parameter int unsigned DIV_W  = 3,
   parameter bit          ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             pre_en,
   input  logic [DIV_W-1:0] pre_val,
   output logic             tick
);
   localparam int unsigned PC_W = 1 << DIV_W;

   generate
      if (ENABLE) begin : g_div
         logic [PC_W-1:0] pc_q;
         logic [PC_W:0]   lim;
         logic            wrap;

         always_comb begin
            lim  = ((PC_W+1)'(1) << (int'(pre_val) + 1)) - (PC_W+1)'(1);
            wrap = (pc_q == lim[PC_W-1:0]);
            tick = run & (~pre_en | wrap);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       pc_q <= '0;
            else if (!run || !pre_en || wrap) pc_q <= '0;
            else                              pc_q <= pc_q + 1'b1;
         end
      end else begin : g_nodiv
         assign tick = run;
      end
   endgenerate
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             reload_en,
   input  logic             cmp_en,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] match_val,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             trig_wr,
   output logic [CNT_W-1:0] cnt,
   output logic             trig_pend,
   output logic             ovf_evt,
   output logic             match_evt,
   output logic             auto_stop
);
   logic [CNT_W-1:0] cnt_q, nxt;
   logic             trig_q, step, at_top;

   always_comb begin
      step   = tick & ~cnt_wr;
      at_top = (cnt_q == {CNT_W{1'b1}});
      if (trig_q)      nxt = load_val;
      else if (at_top) nxt = reload_en ? load_val : '0;
      else             nxt = cnt_q + 1'b1;
      ovf_evt   = step & ~trig_q & at_top;
      match_evt = step & cmp_en & (nxt == match_val);
      auto_stop = ovf_evt & ~reload_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         trig_q <= 1'b0;
      end else begin
         if (cnt_wr)    cnt_q <= cnt_wdata;
         else if (step) cnt_q <= nxt;
         trig_q <= trig_wr | (trig_q & ~step);
      end
   end

   assign cnt       = cnt_q;
   assign trig_pend = trig_q;
endmodule

// File: rtl/cct_capture.sv
module cct_capture
   import cct_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned SYNC_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin,
   input  edge_sel_e        edge_sel,
   input  logic             second_only,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cap_val,
   output logic             cap_evt
);
   logic [SYNC_N-1:0] sync_q;
   logic              prev_q, phase_q, lvl, rise, fall, hit;
   logic [CNT_W-1:0]  cap_q;

   generate
      for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= pin;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[i] <= 1'b0;
               else        sync_q[i] <= sync_q[i-1];
         end
      end
   endgenerate

   always_comb begin
      lvl  = sync_q[SYNC_N-1];
      rise = lvl & ~prev_q;
      fall = ~lvl & prev_q;
      unique case (edge_sel)
         EDGE_RISE: hit = rise;
         EDGE_FALL: hit = fall;
         EDGE_BOTH: hit = rise | fall;
         default:   hit = 1'b0;
      endcase
      cap_evt = hit & (~second_only | phase_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         phase_q <= 1'b0;
         cap_q   <= '0;
      end else begin
         prev_q <= lvl;
         if (!second_only) phase_q <= 1'b0;
         else if (hit)     phase_q <= ~phase_q;
         if (cap_evt) cap_q <= cnt;
      end
   end

   assign cap_val = cap_q;
endmodule

// File: rtl/cct_waveform.sv
module cct_waveform
   import cct_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run,
   input  logic      idle_hi,
   input  logic      toggle,
   input  wave_pol_e pol,
   input  logic      ovf_evt,
   input  logic      match_evt,
   output logic      wave
);
   logic wave_q, ev, nxt;

   always_comb begin
      unique case (pol)
         WAVE_OVF:   ev = ovf_evt;
         WAVE_OVFMT: ev = ovf_evt | match_evt;
         default:    ev = 1'b0;
      endcase
      if (!run)        nxt = idle_hi;
      else if (toggle) nxt = wave_q ^ ev;
      else             nxt = idle_hi ^ ev;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) wave_q <= 1'b0;
      else        wave_q <= nxt;

   assign wave = wave_q;
endmodule

// File: rtl/cc_pwm_timer.sv
module cc_pwm_timer
   import cct_pkg::*;
#(
   parameter int unsigned CNT_W         = 32,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned SYNC_N        = 2,
   parameter bit          HAS_PRESCALER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              cap_in,
   output logic              pwm_out,
   output logic              pwm_oe,
   output logic              irq
);
   generate
      if (CNT_W < 8 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie between 8 and DATA_W");
      end
      if (DATA_W < CTRL_W) begin : g_bad_data
         $error("DATA_W too narrow for the control register");
      end
      if (SYNC_N < 2) begin : g_bad_sync
         $error("SYNC_N must be at least 2");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] load_q, match_q, cnt_val, cap_val;
   logic [IRQ_N-1:0] sts_q, ien_q, sts_set, sts_clr;
   logic             wr, ctrl_wr, cnt_wr, trig_wr, sts_wr, stop_ack;
   logic             tick, trig_pend, ovf_evt, match_evt, auto_stop, cap_evt;
   logic             wave;

   always_comb begin
      wr       = bus_sel & bus_wr;
      ctrl_wr  = wr & (bus_addr == A_CTRL);
      cnt_wr   = wr & (bus_addr == A_CNT);
      trig_wr  = wr & (bus_addr == A_TRIG);
      sts_wr   = wr & (bus_addr == A_STAT);
      stop_ack = ctrl_wr & ctrl_q.run & ~bus_wdata[0];
      sts_set  = '0;
      sts_set[IRQ_MATCH] = match_evt;
      sts_set[IRQ_OVF]   = ovf_evt;
      sts_set[IRQ_CAP]   = cap_evt;
      sts_clr  = sts_wr ? bus_wdata[IRQ_N-1:0] : '0;
      if (stop_ack) sts_clr[IRQ_OVF] = 1'b1;
   end

   cct_prescaler #(.DIV_W(PRE_W), .ENABLE(HAS_PRESCALER)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .pre_en(ctrl_q.pre_en),
      .pre_val(ctrl_q.pre_val), .tick(tick)
   );

   cct_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .reload_en(ctrl_q.reload),
      .cmp_en(ctrl_q.cmp_en), .load_val(load_q), .match_val(match_q),
      .cnt_wr(cnt_wr), .cnt_wdata(bus_wdata[CNT_W-1:0]), .trig_wr(trig_wr),
      .cnt(cnt_val), .trig_pend(trig_pend), .ovf_evt(ovf_evt),
      .match_evt(match_evt), .auto_stop(auto_stop)
   );

   cct_capture #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_cap (
      .clk(clk), .rst_n(rst_n), .pin(cap_in), .edge_sel(ctrl_q.edge_sel),
      .second_only(ctrl_q.cap_second), .cnt(cnt_val), .cap_val(cap_val),
      .cap_evt(cap_evt)
   );

   cct_waveform u_wave (
      .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .idle_hi(ctrl_q.idle_hi),
      .toggle(ctrl_q.toggle), .pol(ctrl_q.wave_pol), .ovf_evt(ovf_evt),
      .match_evt(match_evt), .wave(wave)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         load_q  <= '0;
         match_q <= '0;
         sts_q   <= '0;
         ien_q   <= '0;
      end else begin
         if (ctrl_wr)        ctrl_q     <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
         else if (auto_stop) ctrl_q.run <= 1'b0;
         if (wr && bus_addr == A_LOAD)  load_q  <= bus_wdata[CNT_W-1:0];
         if (wr && bus_addr == A_MATCH) match_q <= bus_wdata[CNT_W-1:0];
         if (wr && bus_addr == A_IEN)   ien_q   <= bus_wdata[IRQ_N-1:0];
         sts_q <= (sts_q & ~sts_clr) | sts_set;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_CTRL:  bus_rdata = DATA_W'(ctrl_q);
         A_CNT:   bus_rdata = DATA_W'(cnt_val);
         A_LOAD:  bus_rdata = DATA_W'(load_q);
         A_MATCH: bus_rdata = DATA_W'(match_q);
         A_CAPT:  bus_rdata = DATA_W'(cap_val);
         A_STAT:  bus_rdata = DATA_W'(sts_q);
         A_IEN:   bus_rdata = DATA_W'(ien_q);
         default: bus_rdata = '0;
      endcase
   end

   assign pwm_out = wave;
   assign pwm_oe  = ~ctrl_q.out_dis;
   assign irq     = |(sts_q & ien_q);
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             reload_en,
   input logic             idle_hi,
   input logic             tick,
   input logic             cnt_wr,
   input logic             ctrl_wr,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] load,
   input logic             trig_pend,
   input logic             ovf_evt,
   input logic             auto_stop,
   input logic             cap_evt,
   input logic [CNT_W-1:0] cap_val,
   input logic [2:0]       sts,
   input logic [2:0]       ien,
   input logic             sts_wr,
   input logic [2:0]       sts_wdata,
   input logic             pwm,
   input logic             irq
);
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cnt_wr) |=> $stable(cnt));

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && !trig_pend && cnt != {CNT_W{1'b1}})
      |=> cnt == $past(cnt) + 1'b1);

   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt && reload_en) |=> cnt == $past(load));

   p_oneshot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_stop && !ctrl_wr) |=> !run);

   p_trigger_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && trig_pend) |=> cnt == $past(load));

   p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> cap_val == $past(cnt));

   p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && sts_wdata[1] && !ovf_evt) |=> !sts[1]);

   p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == 3'b000) |-> !irq);

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> pwm == $past(idle_hi));
endmodule

bind cc_pwm_timer cct_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .reload_en(ctrl_q.reload),
   .idle_hi(ctrl_q.idle_hi), .tick(tick), .cnt_wr(cnt_wr), .ctrl_wr(ctrl_wr),
   .cnt(cnt_val), .load(load_q), .trig_pend(trig_pend), .ovf_evt(ovf_evt),
   .auto_stop(auto_stop), .cap_evt(cap_evt), .cap_val(cap_val), .sts(sts_q),
   .ien(ien_q), .sts_wr(sts_wr), .sts_wdata(bus_wdata[2:0]), .pwm(pwm_out),
   .irq(irq)
);

// File: tb/cc_pwm_timer_bench.sv
module cc_pwm_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cap_in = 1'b0;
   logic        pwm_out, pwm_oe, irq;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   cc_pwm_timer u_cc_pwm_timer (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cap_in(cap_in), .pwm_out(pwm_out), .pwm_oe(pwm_oe), .irq(irq)
   );

   // behavioural reference
   logic [14:0] m_ctrl;
   logic [31:0] m_cnt, m_load, m_match, m_cap;
   logic [2:0]  m_sts, m_ien;
   bit          m_trig, m_s0, m_s1, m_prev, m_phase, m_pwm;
   int          m_pre;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl = '0; m_cnt = '0; m_load = '0; m_match = '0; m_cap = '0;
         m_sts = '0; m_ien = '0; m_trig = 0; m_s0 = 0; m_s1 = 0;
         m_prev = 0; m_phase = 0; m_pwm = 0; m_pre = 0;
      end else begin
         bit w, run, tick, cw, step, ovf, mt, rise, fall, hit, cev, ev;
         int per;
         logic [31:0] nc;
         logic [2:0]  clr;
         w    = bus_sel && bus_wr;
         run  = m_ctrl[0];
         per  = m_ctrl[5] ? (1 << (int'(m_ctrl[4:2]) + 1)) : 1;
         tick = run && (m_pre == per - 1);
         cw   = w && bus_addr == 8'h04;
         step = tick && !cw;
         ovf = 0; mt = 0; nc = m_cnt;
         if (step) begin
            if (m_trig) nc = m_load;
            else if (m_cnt == 32'hFFFF_FFFF) begin
               ovf = 1; nc = m_ctrl[1] ? m_load : 32'h0;
            end else nc = m_cnt + 1;
            mt = m_ctrl[6] && (nc == m_match);
         end
         if (cw) nc = bus_wdata;
         rise = m_s1 && !m_prev;
         fall = !m_s1 && m_prev;
         case (m_ctrl[9:8])
            2'b01: hit = rise;
            2'b10: hit = fall;
            2'b11: hit = rise || fall;
            default: hit = 0;
         endcase
         cev = hit && (!m_ctrl[13] || m_phase);
         ev  = (m_ctrl[11:10] == 2'd1 && ovf) || (m_ctrl[11:10] == 2'd2 && (ovf || mt));
         clr = (w && bus_addr == 8'h18) ? bus_wdata[2:0] : 3'b000;
         if (w && bus_addr == 8'h00 && run && !bus_wdata[0]) clr[1] = 1;
         // commit
         if (!run) m_pwm = m_ctrl[7];
         else if (m_ctrl[12]) m_pwm = m_pwm ^ ev;
         else m_pwm = m_ctrl[7] ^ ev;
         if (cev) m_cap = m_cnt;
         if (!m_ctrl[13]) m_phase = 0; else if (hit) m_phase = !m_phase;
         m_prev = m_s1; m_s1 = m_s0; m_s0 = cap_in;
         m_sts = (m_sts & ~clr) | {cev, ovf, mt};
         m_trig = (w && bus_addr == 8'h0C) || (m_trig && !step);
         m_pre = (!run || !m_ctrl[5] || tick) ? 0 : m_pre + 1;
         m_cnt = nc;
         if (w && bus_addr == 8'h00) m_ctrl = bus_wdata[14:0];
         else if (ovf && !m_ctrl[1]) m_ctrl[0] = 0;
         if (w && bus_addr == 8'h08) m_load = bus_wdata;
         if (w && bus_addr == 8'h10) m_match = bus_wdata;
         if (w && bus_addr == 8'h1C) m_ien = bus_wdata[2:0];
      end
   end

   function automatic logic [31:0] m_read(input logic [7:0] a);
      case (a)
         8'h00: return {17'h0, m_ctrl};
         8'h04: return m_cnt;
         8'h08: return m_load;
         8'h10: return m_match;
         8'h14: return m_cap;
         8'h18: return {29'h0, m_sts};
         8'h1C: return {29'h0, m_ien};
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-clock output comparison
   always @(negedge clk) if (rst_n && !finished) begin
      chk("R11 irq", {31'h0, irq}, {31'h0, |(m_sts & m_ien)});
      chk("R10 pwm_out", {31'h0, pwm_out}, {31'h0, m_pwm});
      chk("R13 pwm_oe", {31'h0, pwm_oe}, {31'h0, !m_ctrl[14]});
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      @(negedge clk); bus_addr = a; #1;
      chk(tag, bus_rdata, m_read(a));
   endtask

   task automatic rdx(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); bus_addr = a; #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pin(input bit v, input int hold);
      @(negedge clk); cap_in = v; idle(hold);
   endtask

   task automatic summary;
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      idle(3);
      #1 rst_n = 1;
      // R1 reset state
      rdx(8'h00, 0, "R1 ctrl"); rdx(8'h04, 0, "R1 cnt");
      rdx(8'h18, 0, "R1 sts");  rdx(8'h1C, 0, "R1 ien");
      rdx(8'h0C, 0, "R1 trig reads zero");
      chk("R1 pwm_out", {31'h0, pwm_out}, 0);
      chk("R1 pwm_oe", {31'h0, pwm_oe}, 1);
      chk("R1 irq", {31'h0, irq}, 0);
      // R3 / R2 write and hold
      wr(8'h04, 32'h1234);
      rdx(8'h04, 32'h1234, "R3 cnt write");
      idle(3);
      rdx(8'h04, 32'h1234, "R2 hold while stopped");
      wr(8'h00, 32'h1);
      rdx(8'h04, 32'h1235, "R2 first tick");
      idle(5);
      rd(8'h04, "R2 free run");
      wr(8'h04, 32'h77);
      rdx(8'h04, 32'h78, "R3 write while running");
      // R5 prescaler
      wr(8'h00, 32'h25);
      idle(21); rd(8'h04, "R5 divide by 4");
      wr(8'h00, 32'h3D);
      idle(600); rd(8'h04, "R5 divide by 256");
      wr(8'h00, 32'h0); idle(3); rd(8'h04, "R5 stopped");
      // R4 overflow with reload, toggle on overflow
      wr(8'h08, 32'h100);
      wr(8'h04, 32'hFFFF_FFFC);
      wr(8'h1C, 32'h7);
      wr(8'h00, 32'h1403);
      idle(10);
      rd(8'h04, "R4 reload"); rd(8'h18, "R4 overflow status");
      wr(8'h18, 32'h2);
      rd(8'h18, "R11 w1c");
      // R4 one-shot, pulse mode with high idle level
      wr(8'h00, 32'h0);
      wr(8'h04, 32'hFFFF_FFFE);
      wr(8'h00, 32'h881);
      idle(6);
      rdx(8'h00, 32'h880, "R4 run cleared");
      rdx(8'h04, 32'h0, "R4 wraps to zero");
      // R7 compare, toggle mode
      wr(8'h18, 32'h7);
      wr(8'h04, 32'h0);
      wr(8'h10, 32'd20);
      wr(8'h00, 32'h1841);
      idle(30);
      rd(8'h18, "R7 match status"); rd(8'h04, "R7 cnt");
      // R6 trigger
      wr(8'h08, 32'h500);
      wr(8'h0C, 32'hDEAD);
      rdx(8'h04, 32'h500, "R6 trigger reload");
      idle(3); rd(8'h04, "R6 after reload");
      // R12 stop acknowledges overflow
      wr(8'h18, 32'h7);
      wr(8'h00, 32'h0);
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h00, 32'h3);
      idle(2);
      rd(8'h18, "R12 overflow pending");
      wr(8'h00, 32'h0);
      rd(8'h18, "R12 after stop");
      chk("R12 ovf bit cleared", {31'h0, bus_rdata[1]}, 0);
      // R8 capture edges
      wr(8'h18, 32'h7);
      wr(8'h00, 32'h101);
      pin(1, 5); rd(8'h14, "R8 rising"); rd(8'h18, "R8 status");
      pin(0, 5); rd(8'h14, "R8 falling ignored");
      wr(8'h00, 32'h201);
      pin(1, 4); pin(0, 4); rd(8'h14, "R8 falling");
      wr(8'h00, 32'h301);
      pin(1, 4); rd(8'h14, "R8 both a");
      pin(0, 4); rd(8'h14, "R8 both b");
      // R9 every second edge
      wr(8'h00, 32'h2301);
      for (int i = 0; i < 4; i++) begin
         pin(!cap_in, 4); rd(8'h14, "R9 second edge");
      end
      // R10 pulse on overflow only, low idle
      wr(8'h00, 32'h0);
      wr(8'h04, 32'hFFFF_FFF0);
      wr(8'h08, 32'hFFFF_FFF8);
      wr(8'h00, 32'h0403);
      idle(40);
      rd(8'h04, "R10 pulse run");
      // R13 output direction
      wr(8'h00, 32'h4000);
      chk("R13 oe low", {31'h0, pwm_oe}, 0);
      wr(8'h00, 32'h0);
      chk("R13 oe high", {31'h0, pwm_oe}, 1);
      idle(2);
      summary();
   end
endmodule